// File: doc/BRIEF.md
# Bistable Pulse Decoder with Idle Watchdog

This block is the receive end of one edge-coded isolation channel. The sending side reports each logic transition as a one-cycle strobe: a set strobe for a rising input and a clear strobe for a falling input. The decoder keeps the last reported level in a bistable register and drives it out, so the received level stays put between strobes.

A watchdog guards against a sending side that has lost power. While the active-low watchdog enable is held low, a counter measures the cycles since the last strobe. If the count reaches the timeout, which is given in clock cycles and is nominally about 200 µs, the output is forced to a default level fixed at build time and a status flag is raised. The timeout must be longer than the sender's refresh interval, so a healthy idle channel keeps restarting it and never trips. While the enable is high the watchdog is off and the output holds its last decoded level indefinitely. In this mode the output can disagree with the sender after power-up until the first transition arrives.

Top module: `iso_rx_decoder`

## Requirements
- R1: A set strobe arriving without a clear strobe makes `dataOut` 1 from the clock edge that samples it.
- R2: A clear strobe arriving without a set strobe makes `dataOut` 0 from the clock edge that samples it.
- R3: A cycle with both strobes high leaves `dataOut` unchanged, but it counts as channel activity and restarts the idle count.
- R4: With `wdogEnN` = 0, the edge that completes `TIMEOUT_CYCLES` consecutive strobe-free cycles sets `dataOut` to `DEFAULT_LEVEL` and `wdogTrip` to 1. After only `TIMEOUT_CYCLES`-1 such cycles, neither output has changed.
- R5: Once tripped, `dataOut` stays at `DEFAULT_LEVEL` and `wdogTrip` stays at 1 until a strobe arrives. The edge that samples that strobe applies the level rules of R1, R2 or R3 and clears `wdogTrip`.
- R6: With `wdogEnN` = 1, `wdogTrip` is 0 from the next edge, the idle count is held at zero, and `dataOut` changes only on strobes, however long the channel stays idle.
- R7: Strobes are decoded in both watchdog modes. With `wdogEnN` = 1, a level that does not match the sender persists until the next strobe and is corrected by it.
- R8: While `rst_n` is low, `dataOut` is `DEFAULT_LEVEL`, `wdogTrip` is 0 and the idle count is zero. After reset, a trip therefore needs a full `TIMEOUT_CYCLES` idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setPulse | input | 1 | One-cycle strobe reporting a rising transition at the sender |
| clrPulse | input | 1 | One-cycle strobe reporting a falling transition at the sender |
| wdogEnN | input | 1 | Active-low watchdog enable (0 = watchdog on) |
| dataOut | output | 1 | Decoded channel level |
| wdogTrip | output | 1 | High while the watchdog default is being applied |

## Verification
Every result of this block is a single register stage away from its cause. A strobe sampled at one edge shows up on `dataOut` and `wdogTrip` straight after that edge. A trip appears exactly after the `TIMEOUT_CYCLES`-th idle edge, never one edge earlier. The bench drives its inputs on falling edges, and a behavioural model advances on each rising edge using the same sampled inputs. The outputs are compared with the model on the following falling edge, half a cycle after every possible change. Directed checks sit at the exact boundary cycles: one cycle before a trip, the trip cycle itself, and the first cycle after a strobe or after a change of mode.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

  // Strobes sent from the control to the level datapath
  typedef struct packed {
    logic takeSet;    // load level 1
    logic takeClr;    // load level 0
    logic forceDef;   // load the default level (watchdog expiry)
  } rxStrobe_t;

endpackage

// File: rtl/iso_rx_ctrl.sv
module iso_rx_ctrl
  import iso_rx_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 25000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      setPulse,
  input  logic      clrPulse,
  input  logic      wdogEnN,
  output rxStrobe_t strobe,
  output logic      tripFlag
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_IDLE = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(TIMEOUT_CYCLES);

  logic [CNT_W-1:0] idleCnt;
  logic             anyPulse;
  logic             expireNow;

  assign anyPulse  = setPulse | clrPulse;
  assign expireNow = !wdogEnN && !anyPulse && !tripFlag && (idleCnt == LAST_IDLE);

  always_comb begin
    strobe.takeSet  = setPulse & ~clrPulse;
    strobe.takeClr  = clrPulse & ~setPulse;
    strobe.forceDef = expireNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idleCnt  <= '0;
      tripFlag <= 1'b0;
    end else if (wdogEnN || anyPulse) begin
      idleCnt  <= '0;
      tripFlag <= 1'b0;
    end else if (!tripFlag) begin
      idleCnt <= idleCnt + 1'b1;
      if (expireNow) tripFlag <= 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idleCnt <= CNT_MAX) else $error("idle count overran");  // R4
  AST_NO_TRIP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    wdogEnN |=> !tripFlag) else $error("trip while disabled");  // R6
  AST_TRIP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripFlag) |-> $past(!setPulse && !clrPulse && !wdogEnN)) else $error("trip without idle");  // R4
  AST_PULSE_CLEARS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (setPulse || clrPulse) |=> !tripFlag) else $error("trip survived a pulse");  // R5

endmodule

// File: rtl/iso_rx_datapath.sv
module iso_rx_datapath
  import iso_rx_pkg::*;
#(
  parameter logic DEFAULT_LEVEL = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rxStrobe_t strobe,
  output logic      levelQ
);

  always_ff @(posedge clk) begin
    if (!rst_n)               levelQ <= DEFAULT_LEVEL;
    else if (strobe.forceDef) levelQ <= DEFAULT_LEVEL;
    else if (strobe.takeSet)  levelQ <= 1'b1;
    else if (strobe.takeClr)  levelQ <= 1'b0;
  end

  AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.takeSet |=> levelQ) else $error("set did not raise level");  // R1
  AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.takeClr |=> !levelQ) else $error("clear did not lower level");  // R2
  AST_FORCE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.forceDef |=> (levelQ == DEFAULT_LEVEL)) else $error("default not applied");  // R4

endmodule

// File: rtl/iso_rx_decoder.sv
module iso_rx_decoder
  import iso_rx_pkg::*;
#(
  parameter int   TIMEOUT_CYCLES = 25000,
  parameter logic DEFAULT_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic setPulse,
  input  logic clrPulse,
  input  logic wdogEnN,
  output logic dataOut,
  output logic wdogTrip
);

  rxStrobe_t strobe;

  iso_rx_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) uCtrl (
    .clk(clk), .rst_n(rst_n), .setPulse(setPulse), .clrPulse(clrPulse),
    .wdogEnN(wdogEnN), .strobe(strobe), .tripFlag(wdogTrip)
  );

  iso_rx_datapath #(.DEFAULT_LEVEL(DEFAULT_LEVEL)) uData (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .levelQ(dataOut)
  );

  AST_TRIP_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    wdogTrip |-> (dataOut == DEFAULT_LEVEL)) else $error("tripped but not default");  // R5
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (setPulse && clrPulse) |=> $stable(dataOut)) else $error("conflict changed level");  // R3
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wdogEnN && !setPulse && !clrPulse) |=> $stable(dataOut)) else $error("idle disabled level moved");  // R6

endmodule

// File: tb/iso_rx_decoder_test.sv
module iso_rx_decoder_test;

  localparam int   TO  = 40;
  localparam logic DEF = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setPulse = 1'b0;
  logic clrPulse = 1'b0;
  logic wdogEnN = 1'b0;
  logic dataOut, wdogTrip;

  int checks = 0;
  int errors = 0;
  string curReq = "R8";

  // behavioural reference state
  logic mOut = DEF;
  logic mTrip = 1'b0;
  int   mIdle = 0;
  bit   started = 0;

  always #4 clk = ~clk;

  iso_rx_decoder #(.TIMEOUT_CYCLES(TO), .DEFAULT_LEVEL(DEF)) uut (
    .clk(clk), .rst_n(rst_n), .setPulse(setPulse), .clrPulse(clrPulse),
    .wdogEnN(wdogEnN), .dataOut(dataOut), .wdogTrip(wdogTrip)
  );

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      mOut <= DEF; mTrip <= 0; mIdle <= 0;
    end else if (setPulse || clrPulse) begin
      mIdle <= 0; mTrip <= 0;
      if (setPulse != clrPulse) mOut <= setPulse;
    end else if (wdogEnN) begin
      mIdle <= 0; mTrip <= 0;
    end else if (mIdle < TO) begin
      mIdle <= mIdle + 1;
      if (mIdle + 1 == TO) begin
        mTrip <= 1; mOut <= DEF;
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk(curReq, dataOut, mOut, "model dataOut");
      chk(curReq, wdogTrip, mTrip, "model wdogTrip");
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic s, input logic c);
    setPulse = s; clrPulse = c;
    @(negedge clk);
    setPulse = 0; clrPulse = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    curReq = "R8";
    chk("R8", dataOut, DEF, "reset level");
    chk("R8", wdogTrip, 1'b0, "reset trip");
    rst_n = 1;

    curReq = "R1";
    strobe(1, 0);
    chk("R1", dataOut, 1'b1, "set gives high");
    curReq = "R2";
    strobe(0, 1);
    chk("R2", dataOut, 1'b0, "clear gives low");
    curReq = "R3";
    strobe(1, 1);
    chk("R3", dataOut, 1'b0, "both hold low");
    idle(TO - 2);
    strobe(1, 1); // activity restarts count
    idle(TO - 1);
    chk("R3", wdogTrip, 1'b0, "conflict restarted count");

    curReq = "R4";
    strobe(0, 1);
    idle(TO - 1);
    chk("R4", wdogTrip, 1'b0, "no trip one cycle early");
    chk("R4", dataOut, 1'b0, "level kept one cycle early");
    idle(1);
    chk("R4", wdogTrip, 1'b1, "trip at timeout");
    chk("R4", dataOut, DEF, "default at timeout");

    curReq = "R5";
    idle(25);
    chk("R5", wdogTrip, 1'b1, "trip persists");
    strobe(0, 1);
    chk("R5", wdogTrip, 1'b0, "pulse clears trip");
    chk("R5", dataOut, 1'b0, "pulse decodes after trip");

    curReq = "R6";
    wdogEnN = 1;
    idle(3 * TO);
    chk("R6", wdogTrip, 1'b0, "no trip when disabled");
    chk("R6", dataOut, 1'b0, "level held when disabled");
    wdogEnN = 0;
    idle(TO - 1);
    chk("R6", wdogTrip, 1'b0, "count held at zero while disabled");
    idle(1);
    chk("R6", wdogTrip, 1'b1, "full timeout after re-enable");
    wdogEnN = 1;
    idle(1);
    chk("R6", wdogTrip, 1'b0, "disable clears trip");
    chk("R6", dataOut, DEF, "disable keeps forced level");

    curReq = "R7";
    strobe(0, 1);
    idle(10);
    chk("R7", dataOut, 1'b0, "mismatch persists disabled");
    strobe(1, 0);
    chk("R7", dataOut, 1'b1, "transition corrects level");
    wdogEnN = 0;

    curReq = "R8";
    strobe(0, 1);
    idle(TO - 5);
    rst_n = 0;
    idle(1);
    chk("R8", dataOut, DEF, "reset mid-run level");
    chk("R8", wdogTrip, 1'b0, "reset mid-run trip");
    rst_n = 1;
    idle(TO - 1);
    chk("R8", wdogTrip, 1'b0, "reset cleared count");
    idle(1);
    chk("R8", wdogTrip, 1'b1, "trip after full timeout");

    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule